// File: doc/BRIEF.md
# Carry-Pipelined Split Binary Counter

This block is a wide, free-running binary up-counter. It is divided into a lower and an upper sub-counter so that no single ripple of carry logic spans the whole width. The lower half advances on every enabled clock. The upper half advances only when the lower half rolls over.

The carry from the lower half to the upper half is taken from a flip-flop, not from a live comparison. That flip-flop is loaded one count early. It is set on the enabled edge that brings the lower half to all-ones, and it keeps its value while enable is low. As a result, the upper half steps on the same edge at which the lower half returns to zero. The concatenated output therefore never lags a plain binary count.

The block has only plain control and status pins: a clock, a synchronous reset, an enable and the count. There is no streaming interface, so no back-pressure applies. The widths are parameters; the default is 22 bits split 11/11. The lower half must be at least two bits wide.

Top module: `carry_split_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count` is 0 after that edge, whatever the level of `en`.
- R2: When `rst` is low and `en` is high at a rising edge, `count` after that edge equals its previous value plus one, modulo 2^TOTAL_W.
- R3: When `rst` is low and `en` is low at a rising edge, `count` keeps its value.
- R4: On the enabled edge where bits [LOW_W-1:0] of `count` go from all-ones to zero, bits [TOTAL_W-1:LOW_W] increase by one on that same edge. `count` never shows a stale upper half.
- R5: From 2^TOTAL_W-1 (4194303 at default widths), an enabled edge returns `count` to 0.
- R6: The registered carry survives a pause. If `en` goes low while the lower half is all-ones, the next enabled edge still increments the upper half, and the upper half changes at no other time.
- R7: The carry register holds exactly when the lower half is all-ones, so the upper half's enable depends on one flip-flop and never on the lower half's adder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears both halves and the carry flip-flop |
| en | input | 1 | Count enable, active high |
| count | output | TOTAL_W | Current count; upper half concatenated above lower half |

## Verification
Every result is due exactly one rising edge after the inputs that cause it, because `count` comes straight from flip-flops. The driver applies inputs at the falling edge and pushes the value the count must hold after the next rising edge. The monitor pops that value a quarter period after that rising edge and compares it, so each comparison refers to exactly one edge. The bench also runs a second, narrower instance next to the default one, so that a complete wrap of the full count fits within the run.

// File: rtl/carry_split_counter_pkg.sv
package carry_split_counter_pkg;
  // default geometry of the split counter
  localparam int unsigned DEF_TOTAL_W = 22;
  localparam int unsigned DEF_LOW_W   = 11;

  // value one below all-ones for a segment of the given width
  function automatic logic [31:0] seg_near_top(input int unsigned w);
    logic [31:0] v;
    v = (32'd1 << w) - 32'd2;
    return v;
  endfunction
endpackage

// File: rtl/csc_low_seg.sv
module csc_low_seg #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         near_top
);
  import carry_split_counter_pkg::*;

  localparam logic [31:0]  NEAR_WIDE = seg_near_top(W);
  localparam logic [W-1:0] NEAR      = NEAR_WIDE[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (step) value <= value + 1'b1;
  end

  // equality on this segment only; the adder output is not involved
  assign near_top = (value == NEAR);
endmodule

// File: rtl/csc_carry_reg.sv
module csc_carry_reg (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic near_top,
  output logic carry_q
);
  // set on the edge that brings the lower half to all-ones, kept while idle
  always_ff @(posedge clk) begin
    if (rst)       carry_q <= 1'b0;
    else if (step) carry_q <= near_top;
  end
endmodule

// File: rtl/csc_high_seg.sv
module csc_high_seg #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (step) value <= value + 1'b1;
  end
endmodule

// File: rtl/carry_split_counter.sv
module carry_split_counter #(
  parameter int unsigned TOTAL_W = carry_split_counter_pkg::DEF_TOTAL_W,
  parameter int unsigned LOW_W   = carry_split_counter_pkg::DEF_LOW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic [TOTAL_W-1:0] count
);
  localparam int unsigned HIGH_W = TOTAL_W - LOW_W;

  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;
  logic              near_top;
  logic              carry_q;
  logic              high_step;

  csc_low_seg #(.W(LOW_W)) u_low (
    .clk      (clk),
    .rst      (rst),
    .step     (en),
    .value    (low_q),
    .near_top (near_top)
  );

  csc_carry_reg u_carry (
    .clk      (clk),
    .rst      (rst),
    .step     (en),
    .near_top (near_top),
    .carry_q  (carry_q)
  );

  // the upper enable is one flip-flop ANDed with the input enable
  assign high_step = en & carry_q;

  csc_high_seg #(.W(HIGH_W)) u_high (
    .clk   (clk),
    .rst   (rst),
    .step  (high_step),
    .value (high_q)
  );

  assign count = {high_q, low_q};
endmodule

// File: rtl/carry_split_counter_chk.sv
module carry_split_counter_chk #(
  parameter int unsigned TOTAL_W = 22,
  parameter int unsigned LOW_W   = 11,
  parameter int unsigned HIGH_W  = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [TOTAL_W-1:0] count,
  input logic [LOW_W-1:0]   low_q,
  input logic [HIGH_W-1:0]  high_q,
  input logic               carry_q
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (count == '0));

  assert_enabled_step_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> (count == TOTAL_W'($past(count) + 1'b1)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  assert_upper_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (en && (&low_q)) |=> (high_q == HIGH_W'($past(high_q) + 1'b1)));

  assert_upper_still_R6: assert property (@(posedge clk) disable iff (rst)
    !(en && (&low_q)) |=> $stable(high_q));

  assert_carry_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    carry_q == (&low_q));
endmodule

bind carry_split_counter carry_split_counter_chk #(
  .TOTAL_W (TOTAL_W),
  .LOW_W   (LOW_W),
  .HIGH_W  (HIGH_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .count   (count),
  .low_q   (low_q),
  .high_q  (high_q),
  .carry_q (carry_q)
);

// File: tb/carry_split_counter_test.sv
module carry_split_counter_test;
  localparam int PERIOD   = 10;
  localparam int WIDE_W   = 22;
  localparam int WIDE_LW  = 11;
  localparam int NAR_W    = 12;
  localparam int NAR_LW   = 6;
  localparam int WIDE_MSK = (1 << WIDE_W) - 1;
  localparam int WLOW_MSK = (1 << WIDE_LW) - 1;
  localparam int NAR_MSK  = (1 << NAR_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [WIDE_W-1:0] count_w;
  logic [NAR_W-1:0]  count_n;

  int checks   = 0;
  int failures = 0;
  int model    = 0;
  bit done     = 1'b0;

  int    exp_w_q[$];
  int    exp_n_q[$];
  string tag_w_q[$];
  string tag_n_q[$];

  always #(PERIOD/2) clk = ~clk;

  carry_split_counter uut (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .count (count_w)
  );

  carry_split_counter #(.TOTAL_W(NAR_W), .LOW_W(NAR_LW)) uut_narrow (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .count (count_n)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // driver: apply inputs at falling edge, push expected post-edge values
  task automatic step(input logic r, input logic e, input string hint);
    int    prev;
    string tw;
    string tn;
    @(negedge clk);
    rst  = r;
    en   = e;
    prev = model;
    if (r)      model = 0;
    else if (e) model = model + 1;
    if (hint != "")                        tw = hint;
    else if (r)                            tw = "R1";
    else if (!e)                           tw = "R3";
    else if ((prev & WLOW_MSK) == WLOW_MSK) tw = "R4";
    else                                   tw = "R2";
    tn = (!r && e && ((prev & NAR_MSK) == NAR_MSK)) ? "R5" : tw;
    exp_w_q.push_back(model & WIDE_MSK);
    exp_n_q.push_back(model & NAR_MSK);
    tag_w_q.push_back(tw);
    tag_n_q.push_back(tn);
  endtask

  // monitor: one item per rising edge, sampled a quarter period later
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (exp_w_q.size() > 0) begin
        int    ew;
        int    en_v;
        string tw;
        string tn;
        ew   = exp_w_q.pop_front();
        en_v = exp_n_q.pop_front();
        tw   = tag_w_q.pop_front();
        tn   = tag_n_q.pop_front();
        checks++;
        if (int'(count_w) != ew) begin
          failures++;
          $display("FAIL %s wide count actual=%0d expected=%0d", tw, count_w, ew);
        end
        checks++;
        if (int'(count_n) != en_v) begin
          failures++;
          $display("FAIL %s narrow count actual=%0d expected=%0d", tn, count_n, en_v);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(PERIOD * 60000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    // R1: reset with enable high holds zero
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R1");
    // R2, R4, R5: long enabled run, several lower wraps and narrow full wraps
    for (int i = 0; i < 9000; i++) step(1'b0, 1'b1, "");
    // R3: idle hold
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R3");
    // mixed enable pattern
    for (int i = 0; i < 3000; i++) step(1'b0, ($urandom_range(0, 3) != 0), "");
    // R6: park the lower half at all-ones, pause, then resume
    while ((model & WLOW_MSK) != WLOW_MSK) step(1'b0, 1'b1, "");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b1, "R6");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, "");
    // R1: reset mid-count overrides enable
    step(1'b1, 1'b1, "R1");
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, "");
    step(1'b0, 1'b0, "");
    repeat (3) @(negedge clk);
    while (exp_w_q.size() > 0) @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end
endmodule